// File: doc/BRIEF.md
# Single-Wire Slave Slot Front End

This block is the physical-layer front end of a slave on one open-drain data line, shared by the host and the slave and held high by an external pull-up. It samples the line with the system clock and counts time in ticks of an external microsecond strobe. Every event on the line is inferred from how long the host holds the line low. A long low is a bus reset, which the slave answers with a presence pulse. A short low opens a bit slot. The slot is either a write slot, where the host sends a bit, or a read slot, where the slave holds the line low to send a 0.

Upper command layers see a byte interface. Received bits are assembled into bytes, least significant bit first, and each finished byte is announced with a one-cycle strobe. In transmit mode the layer above loads a byte when the block requests one, and the block then serves that byte in the following read slots, least significant bit first. A separate one-cycle strobe reports each detected bus reset. The output is a pull-down enable, and the block never drives the line high.

Top module: `sw_slot_frontend`

## Requirements
- R1: The block only ever asserts `pull_low` for a presence pulse or for a read-0 slot. It keeps `pull_low` low out of reset and while the line is idle.
- R2: A low of at least `T_RESET` ticks produces a one-cycle `bus_reset` pulse after the line is released. The reset also discards any partially received or partially sent byte.
- R3: After a bus reset the block waits `T_PDLY` ticks from release and then asserts `pull_low` for `T_PLEN` ticks (the presence pulse).
- R4: In receive mode (`tx_mode`=0), the line level `T_SAMPLE` ticks after the falling edge is the received bit. A low line at that point gives 0 and a released line gives 1.
- R5: Eight received bits form a byte with the first bit in bit 0. `rx_valid` pulses for exactly one cycle with the byte on `rx_byte`.
- R6: In transmit mode with a byte queued, a slot whose current bit is 0 makes the block assert `pull_low` from the detected falling edge until `T_HOLD0` ticks have passed. A slot whose current bit is 1 leaves the line released.
- R7: `tx_req` is high while `tx_mode`=1 and no byte is queued. A `tx_load` pulse while `tx_req` is high queues `tx_byte`, which is sent bit 0 first over eight read slots. After those eight slots, `tx_req` rises again.
- R8: In transmit mode with no byte queued, read slots leave the line released, so they read as 1. These slots produce no `rx_valid`.
- R9: A low longer than `T_ABORT` ticks but shorter than `T_RESET` ticks discards the partial byte. It produces no `bus_reset` and no presence pulse.
- R10: The line may stay idle for any time between slots without losing the partial byte.
- R11: The falling edge caused by the block's own pull-down, for example its presence pulse, never opens a slot or counts as a received bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe (nominally 1 us) |
| line_in | input | 1 | Raw level of the shared data line |
| pull_low | output | 1 | Enable for the open-drain pull-down |
| tx_mode | input | 1 | 1: slots are read slots served by the slave; 0: slots carry host data |
| tx_load | input | 1 | Queue `tx_byte` for transmission |
| tx_byte | input | DATA_W | Byte to transmit, bit 0 first |
| tx_req | output | 1 | Transmit mode with no byte queued |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` holds a new byte |
| rx_byte | output | DATA_W | Last received byte, first bit in bit 0 |
| bus_reset | output | 1 | One-cycle strobe on each detected bus reset |

## Verification
The bench scales the timing parameters down to a few ticks: sample 3, read-0 hold 4, abort 10, reset 20, presence delay 3 and presence length 6. The tick fires every second clock. With this setting a long reset is about 50 clocks, so the bench can send all 256 byte values through write slots with varying idle gaps. It can also send a spread of values through read slots, and measure presence delay and length to the clock. The same setting puts aborts between 10 and 20 ticks and resets in the middle of a byte within easy reach, as are read slots with nothing queued.

// File: rtl/sw_slot_pkg.sv
// Shared types for the single-wire slot front end.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sw_slot_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,   // line high, waiting for a host falling edge
        ST_LOW    = 3'd1,   // inside a low period, timing it
        ST_PWAIT  = 3'd2,   // reset seen, waiting before presence
        ST_PDRIVE = 3'd3,   // driving the presence pulse
        ST_RECOV  = 3'd4    // waiting for the line to read high again
    } slot_st_t;
endpackage

// File: rtl/sw_line_sync.sv
// Synchronizes the raw line and produces edge strobes.
// Falling edges are masked while the slave's own pull-down is active or
// was active within the synchronizer latency.
// Assumes: line_raw is asynchronous to clk; reset value is the idle level.
module sw_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    input  logic self_pull,
    output logic line_s,
    output logic fall,
    output logic rise
);
    logic [1:0] sync_q;
    logic       prev_q;
    logic [2:0] pull_hist_q;

    // Two-flop synchronizer, previous-level register and own-drive history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q      <= 2'b11;
            prev_q      <= 1'b1;
            pull_hist_q <= '0;
        end else begin
            sync_q      <= {sync_q[0], line_raw};
            prev_q      <= sync_q[1];
            pull_hist_q <= {pull_hist_q[1:0], self_pull};
        end
    end

    assign line_s = sync_q[1];
    assign fall   = prev_q & ~sync_q[1] & ~self_pull & ~(|pull_hist_q);
    assign rise   = ~prev_q & sync_q[1];
endmodule

// File: rtl/sw_slot_timer.sv
// Times low periods in ticks and classifies them as bit slots, aborts
// or bus resets. Drives presence pulses and read-0 holds.
// Assumes: T_SAMPLE <= T_ABORT < T_RESET, T_PDLY >= 1, T_PLEN >= 1.
module sw_slot_timer
    import sw_slot_pkg::*;
#(
    parameter int T_SAMPLE = 30,
    parameter int T_HOLD0  = 30,
    parameter int T_ABORT  = 120,
    parameter int T_RESET  = 480,
    parameter int T_PDLY   = 30,
    parameter int T_PLEN   = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_s,
    input  logic fall,
    input  logic rise,
    input  logic drive0_req,
    output logic pull,
    output logic bit_done,
    output logic bit_val,
    output logic clear,
    output logic reset_det
);
    localparam int CW = $clog2(T_RESET + 1);
    localparam logic [CW-1:0] K_SAMPLE = CW'(T_SAMPLE);
    localparam logic [CW-1:0] K_HOLD0  = CW'(T_HOLD0);
    localparam logic [CW-1:0] K_ABORT  = CW'(T_ABORT);
    localparam logic [CW-1:0] K_RESET  = CW'(T_RESET);
    localparam logic [CW-1:0] K_PDLY1  = CW'(T_PDLY - 1);
    localparam logic [CW-1:0] K_PLEN1  = CW'(T_PLEN - 1);

    slot_st_t       st_q;
    logic [CW-1:0]  cnt_q;
    logic           smp_q;
    logic           drive0_q;

    // Slot state machine: low-period timing, classification, presence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            smp_q     <= 1'b1;
            drive0_q  <= 1'b0;
            bit_done  <= 1'b0;
            bit_val   <= 1'b1;
            clear     <= 1'b0;
            reset_det <= 1'b0;
        end else begin
            bit_done  <= 1'b0;
            clear     <= 1'b0;
            reset_det <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (fall) begin
                        st_q     <= ST_LOW;
                        cnt_q    <= '0;
                        smp_q    <= 1'b1;
                        drive0_q <= drive0_req;
                    end
                end
                ST_LOW: begin
                    if (rise) begin
                        drive0_q <= 1'b0;
                        if (cnt_q >= K_RESET) begin
                            reset_det <= 1'b1;
                            clear     <= 1'b1;
                            st_q      <= ST_PWAIT;
                            cnt_q     <= '0;
                        end else if (cnt_q > K_ABORT) begin
                            st_q <= ST_IDLE;
                        end else begin
                            bit_done <= 1'b1;
                            bit_val  <= smp_q;
                            st_q     <= ST_IDLE;
                        end
                    end else if (tick) begin
                        if (cnt_q < K_RESET) cnt_q <= cnt_q + 1'b1;
                        if (cnt_q + 1'b1 == K_SAMPLE) smp_q <= line_s;
                        if (cnt_q == K_ABORT) clear <= 1'b1;
                    end
                end
                ST_PWAIT: begin
                    if (tick) begin
                        if (cnt_q == K_PDLY1) begin
                            st_q  <= ST_PDRIVE;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_PDRIVE: begin
                    if (tick) begin
                        if (cnt_q == K_PLEN1) begin
                            st_q  <= ST_RECOV;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_RECOV: begin
                    if (line_s) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Pull-down request: presence pulse or the hold of a read-0 slot.
    assign pull = (st_q == ST_PDRIVE) |
                  ((st_q == ST_LOW) & drive0_q & (cnt_q < K_HOLD0));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= K_RESET);
    p_release_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_PWAIT || st_q == ST_RECOV) |-> !pull);
    p_reset_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reset_det |-> !pull && !bit_done);
endmodule

// File: rtl/sw_byte_shift.sv
// LSB-first byte assembly for received bits and disassembly for
// transmitted bits, with a single-byte transmit holding register.
// Assumes: bit_done is a one-cycle strobe; clear has priority.
module sw_byte_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         bit_done,
    input  logic         bit_val,
    input  logic         tx_mode,
    input  logic         tx_load,
    input  logic [W-1:0] tx_data,
    output logic         rx_valid,
    output logic [W-1:0] rx_data,
    output logic         tx_req,
    output logic         drive0_req
);
    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] LAST = BW'(W - 1);

    logic [W-1:0]  rx_sh_q;
    logic [BW-1:0] rx_cnt_q;
    logic [W-1:0]  tx_sh_q;
    logic [BW-1:0] tx_cnt_q;
    logic          tx_full_q;
    logic [W-1:0]  rx_next;

    assign rx_next = {bit_val, rx_sh_q[W-1:1]};

    // Receive path: shift in bits, publish the byte after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh_q  <= '0;
            rx_cnt_q <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (clear) begin
                rx_cnt_q <= '0;
            end else if (bit_done && !tx_mode) begin
                rx_sh_q <= rx_next;
                if (rx_cnt_q == LAST) begin
                    rx_cnt_q <= '0;
                    rx_valid <= 1'b1;
                    rx_data  <= rx_next;
                end else begin
                    rx_cnt_q <= rx_cnt_q + 1'b1;
                end
            end
        end
    end

    // Transmit path: load a byte when empty, shift one bit per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q   <= '0;
            tx_cnt_q  <= '0;
            tx_full_q <= 1'b0;
        end else if (clear) begin
            tx_cnt_q  <= '0;
            tx_full_q <= 1'b0;
        end else if (tx_load && !tx_full_q) begin
            tx_sh_q   <= tx_data;
            tx_cnt_q  <= '0;
            tx_full_q <= 1'b1;
        end else if (bit_done && tx_mode && tx_full_q) begin
            tx_sh_q <= {1'b1, tx_sh_q[W-1:1]};
            if (tx_cnt_q == LAST) begin
                tx_cnt_q  <= '0;
                tx_full_q <= 1'b0;
            end else begin
                tx_cnt_q <= tx_cnt_q + 1'b1;
            end
        end
    end

    assign tx_req     = tx_mode & ~tx_full_q;
    assign drive0_req = tx_mode & tx_full_q & ~tx_sh_q[0];

    p_rx_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_done && !clear && !tx_load) |=> $stable(tx_full_q));
    p_req_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mode |-> !tx_req && !drive0_req);
endmodule

// File: rtl/sw_slot_frontend.sv
// Top of the single-wire slave slot front end: synchronizer, slot timer
// and byte shifter. Output is an open-drain pull-down enable.
// Assumes: tick is a one-cycle strobe from a free-running time base.
module sw_slot_frontend #(
    parameter int DATA_W   = 8,
    parameter int T_SAMPLE = 30,
    parameter int T_HOLD0  = 30,
    parameter int T_ABORT  = 120,
    parameter int T_RESET  = 480,
    parameter int T_PDLY   = 30,
    parameter int T_PLEN   = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_in,
    output logic              pull_low,
    input  logic              tx_mode,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_req,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_byte,
    output logic              bus_reset
);
    logic line_s, fall, rise;
    logic bit_done, bit_val, clear, drive0_req;

    sw_line_sync i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_raw  (line_in),
        .self_pull (pull_low),
        .line_s    (line_s),
        .fall      (fall),
        .rise      (rise)
    );

    sw_slot_timer #(
        .T_SAMPLE (T_SAMPLE),
        .T_HOLD0  (T_HOLD0),
        .T_ABORT  (T_ABORT),
        .T_RESET  (T_RESET),
        .T_PDLY   (T_PDLY),
        .T_PLEN   (T_PLEN)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .line_s     (line_s),
        .fall       (fall),
        .rise       (rise),
        .drive0_req (drive0_req),
        .pull       (pull_low),
        .bit_done   (bit_done),
        .bit_val    (bit_val),
        .clear      (clear),
        .reset_det  (bus_reset)
    );

    sw_byte_shift #(
        .W (DATA_W)
    ) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .bit_done   (bit_done),
        .bit_val    (bit_val),
        .tx_mode    (tx_mode),
        .tx_load    (tx_load),
        .tx_data    (tx_byte),
        .rx_valid   (rx_valid),
        .rx_data    (rx_byte),
        .tx_req     (tx_req),
        .drive0_req (drive0_req)
    );

    p_reset_no_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !rx_valid);
endmodule

// File: tb/test_sw_slot_frontend.sv
module test_sw_slot_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int P_SAMPLE = 3, P_HOLD0 = 4, P_ABORT = 10;
    localparam int P_RESET = 20, P_PDLY = 3, P_PLEN = 6;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic host_low = 1'b0;
    logic tx_mode = 1'b0, tx_load = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic pull_low, tx_req, rx_valid, bus_reset;
    logic [7:0] rx_byte;
    logic line_w;

    int checks = 0, fails = 0;
    int cyc = 0, rx_cnt = 0, rst_cnt = 0, pull_cnt = 0, pull_rise_cyc = 0;
    logic [7:0] rx_last = 8'h00;
    logic pull_prev = 1'b0;

    assign line_w = ~(host_low | pull_low);

    sw_slot_frontend #(
        .DATA_W (8), .T_SAMPLE (P_SAMPLE), .T_HOLD0 (P_HOLD0),
        .T_ABORT (P_ABORT), .T_RESET (P_RESET), .T_PDLY (P_PDLY), .T_PLEN (P_PLEN)
    ) i_sw_slot_frontend (
        .clk (clk), .rst_n (rst_n), .tick (tick), .line_in (line_w),
        .pull_low (pull_low), .tx_mode (tx_mode), .tx_load (tx_load),
        .tx_byte (tx_byte), .tx_req (tx_req), .rx_valid (rx_valid),
        .rx_byte (rx_byte), .bus_reset (bus_reset)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // Tick every second clock, changed away from the active edge.
    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    // Output monitor, sampled at the falling edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rx_valid) begin rx_cnt = rx_cnt + 1; rx_last = rx_byte; end
        if (bus_reset) rst_cnt = rst_cnt + 1;
        if (pull_low) pull_cnt = pull_cnt + 1;
        if (pull_low && !pull_prev) pull_rise_cyc = cyc;
        pull_prev = pull_low;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write_bit(input bit b, input int gap);
        host_low = 1'b1;
        wait_clk(b ? 2 : 16);
        host_low = 1'b0;
        wait_clk(gap);
    endtask

    task automatic host_read_bit(output bit b);
        host_low = 1'b1;
        wait_clk(4);
        host_low = 1'b0;
        wait_clk(3);
        b = line_w;
        wait_clk(20);
    endtask

    task automatic send_byte(input logic [7:0] v, input int gap);
        for (int i = 0; i < 8; i++) host_write_bit(v[i], gap);
        wait_clk(4);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            bit b;
            host_read_bit(b);
            v[i] = b;
        end
    endtask

    task automatic bus_reset_seq(output int rel_cyc);
        host_low = 1'b1;
        wait_clk(2 * (P_RESET + 4));
        host_low = 1'b0;
        rel_cyc = cyc;
        wait_clk(60);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int rel, p0, r0, n0, len, dly;
        logic [7:0] got;
        wait_clk(5);
        // R1: reset state of every output
        check(pull_low == 1'b0, "R1 pull after reset", pull_low, 0);
        check(rx_valid == 1'b0 && bus_reset == 1'b0, "R1 strobes after reset", rx_valid, 0);
        check(tx_req == 1'b0, "R7 tx_req after reset", tx_req, 0);
        rst_n = 1'b1;
        wait_clk(50);
        check(pull_cnt == 0, "R1 idle line released", pull_cnt, 0);

        // R2/R3: bus reset and presence timing
        p0 = pull_cnt;
        bus_reset_seq(rel);
        len = pull_cnt - p0;
        dly = pull_rise_cyc - rel;
        check(rst_cnt == 1, "R2 bus_reset pulses", rst_cnt, 1);
        check(len >= 2*P_PLEN - 1 && len <= 2*P_PLEN, "R3 presence length", len, 2*P_PLEN);
        check(dly >= 2*P_PDLY && dly <= 2*P_PDLY + 6, "R3 presence delay", dly, 2*P_PDLY + 3);
        // R11: presence pulse did not leave a stray bit
        send_byte(8'h5A, 10);
        check(rx_cnt == 1 && rx_last == 8'h5A, "R11 first byte after presence", rx_last, 8'h5A);

        // R4/R5/R10: every byte value, varying idle gaps
        for (int v = 0; v < 256; v++) begin
            n0 = rx_cnt;
            send_byte(v[7:0], 8 + (v % 4) * 4);
            check(rx_cnt == n0 + 1 && rx_last == v[7:0], "R4 R5 R10 received byte", rx_last, v);
        end

        // R9: abort between the limits discards partial byte, no presence
        host_write_bit(1'b0, 10); host_write_bit(1'b1, 10); host_write_bit(1'b0, 10);
        p0 = pull_cnt; r0 = rst_cnt;
        host_low = 1'b1; wait_clk(2 * (P_ABORT + 4)); host_low = 1'b0;
        wait_clk(40);
        check(rst_cnt == r0, "R9 no bus_reset on abort", rst_cnt, r0);
        check(pull_cnt == p0, "R9 no presence on abort", pull_cnt - p0, 0);
        send_byte(8'hA5, 10);
        check(rx_last == 8'hA5, "R9 partial byte dropped", rx_last, 8'hA5);

        // R2: reset inside a byte discards progress
        for (int i = 0; i < 5; i++) host_write_bit(1'b1, 10);
        bus_reset_seq(rel);
        check(rst_cnt == r0 + 1, "R2 reset mid-byte", rst_cnt, r0 + 1);
        n0 = rx_cnt;
        send_byte(8'h3C, 10);
        check(rx_cnt == n0 + 1 && rx_last == 8'h3C, "R2 byte after reset", rx_last, 8'h3C);

        // R6/R7: transmit sweep
        tx_mode = 1'b1;
        wait_clk(2);
        n0 = rx_cnt;
        for (int v = 0; v < 256; v += 17) begin
            check(tx_req == 1'b1, "R7 request when empty", tx_req, 1);
            tx_byte = v[7:0]; tx_load = 1'b1; wait_clk(1); tx_load = 1'b0; wait_clk(1);
            check(tx_req == 1'b0, "R7 request drops after load", tx_req, 0);
            read_byte(got);
            check(got == v[7:0], "R6 R7 read slots carry byte", got, v);
        end
        check(tx_req == 1'b1, "R7 request after eight slots", tx_req, 1);

        // R8: nothing queued reads as ones, no receive strobe
        read_byte(got);
        check(got == 8'hFF, "R8 empty read returns ones", got, 8'hFF);
        check(rx_cnt == n0, "R8 no rx_valid in transmit mode", rx_cnt, n0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule